// File: doc/BRIEF.md
# Sampling ADC Parallel Read Controller

This block sits on the host side of an external 10-bit successive-approximation converter that has an 8-bit parallel data bus. When asked for a sample, it drives the active-low convert-start line and waits for the converter's busy line to fall. It then fetches the result with two byte reads, each using chip-select and read strobes. The upper eight bits come first and the two lowest bits come second. The assembled 10-bit value appears on the output together with a one-cycle valid strobe.

The resting level of the convert-start line selects how the converter behaves between samples. In power-saving mode the line rests low, so the converter drops into its low-current state after each conversion. In that mode every sample begins with a rising edge and a power-up wait before the falling edge that starts the conversion. In the fast mode the line rests high and each sample is a short low pulse. After reset the line is low, because the converter starts powered down. All timing is set in clock cycles by parameters: the pulse width, the power-up wait, the minimum acquisition gap, the chip-select setup and the read strobe width. If busy never falls, a timeout abandons the sample and raises an error pulse.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, the convert-start output is low, chip-select and read are high, and the valid and error outputs are low.
- R2: With the mode input low (fast mode), and convert-start already resting high, a sample produces a low pulse of exactly CNV_LOW_CYC cycles. Convert-start then stays high through the conversion and after the result is delivered.
- R3: When convert-start rests low (after reset, or with the mode input high), a sample first raises it. The line is held high for at least PWRUP_CYC cycles before the falling edge. With the mode input high, the line then stays low after that falling edge, including when the result is delivered.
- R4: A falling edge of convert-start never comes fewer than ACQ_CYC cycles after the previous falling edge of busy.
- R5: After busy falls, exactly two read transactions follow. In each one, chip-select goes low CS_SETUP_CYC cycles before read goes low. Read then stays low for exactly RD_CYC cycles. Read is never low while chip-select is high.
- R6: The result equals {first byte, second byte bits [7:6]}, and bits [5:0] of the second byte have no effect. Valid is high for exactly one cycle per result. The result output changes only together with valid.
- R7: If busy has not fallen TIMEOUT_CYC cycles after the controller starts waiting for it, error pulses for one cycle. No read transaction and no valid pulse follow, and the next request is served normally.
- R8: A request that arrives while a sample is in progress is held and served once the current sample completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_req | input | 1 | One-cycle request for a new sample |
| pd_mode | input | 1 | 1: converter rests powered down between samples; 0: fast mode |
| adc_busy | input | 1 | Converter busy line, asynchronous |
| adc_data | input | BUS_W | Converter parallel data bus |
| adc_convst_n | output | 1 | Convert-start line; its falling edge starts a conversion |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| sample_data | output | RES_W | Assembled conversion result |
| sample_valid | output | 1 | One-cycle strobe marking a new result |
| sample_err | output | 1 | One-cycle strobe marking a busy timeout |

## Verification
A wrong internal sequencing state shows up at the converter pins within a few cycles. It appears as a convert-start pulse of the wrong width, a falling edge that arrives too early after power-up or after the previous busy fall, or a read strobe whose width or chip-select lead is off. A wrong byte capture or assembly appears on the result output at the valid strobe of that same sample. A lost or duplicated request appears as a missing or surplus valid strobe, at the latest by the end of the next sample. A broken timeout path appears as a missing error pulse, or as a hung controller that never serves the next request.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_ARM,
    ST_CNVLO,
    ST_WAITB,
    ST_CS1,
    ST_RD1,
    ST_REC,
    ST_CS2,
    ST_RD2
  } ctl_state_t;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= {STAGES{RST_VAL}};
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = ld || (cnt_q != '0);
    if (ld) begin
      cnt_d = ld_val - 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_pack.sv
module adc_rd_pack #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_hi,
  input  logic             cap_lo,
  input  logic [BUS_W-1:0] byte_in,
  output logic [RES_W-1:0] res,
  output logic             res_vld
);

  localparam int unsigned LSB_W = RES_W - BUS_W;
  localparam int unsigned SHIFT = BUS_W - LSB_W;

  logic [BUS_W-1:0]   hi_q;
  logic [2*BUS_W-1:0] joined;
  logic [RES_W-1:0]   res_d;
  logic [RES_W-1:0]   res_q;
  logic               vld_q;

  always_comb begin
    joined = {hi_q, byte_in};
    res_d  = RES_W'(joined >> SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (cap_hi) begin
      hi_q <= byte_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (cap_lo) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= cap_lo;
    end
  end

  assign res     = res_q;
  assign res_vld = vld_q;

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned RES_W        = 10,
  parameter int unsigned BUS_W        = 8,
  parameter int unsigned CNV_LOW_CYC  = 3,
  parameter int unsigned PWRUP_CYC    = 12,
  parameter int unsigned ACQ_CYC      = 30,
  parameter int unsigned CS_SETUP_CYC = 2,
  parameter int unsigned RD_CYC       = 3,
  parameter int unsigned TIMEOUT_CYC  = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_req,
  input  logic             pd_mode,
  input  logic             adc_busy,
  input  logic [BUS_W-1:0] adc_data,
  output logic             adc_convst_n,
  output logic             adc_cs_n,
  output logic             adc_rd_n,
  output logic [RES_W-1:0] sample_data,
  output logic             sample_valid,
  output logic             sample_err
);

  localparam int unsigned MAX_CYC =
    max_of4(max_of4(CNV_LOW_CYC, PWRUP_CYC, ACQ_CYC, CS_SETUP_CYC), RD_CYC, TIMEOUT_CYC, 1);
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  logic rst_n_s;
  logic busy_s;
  logic busy_prev_q;
  logic busy_fall;

  ctl_state_t state_q, state_d;
  logic       conv_q, conv_d;
  logic       mode_q, mode_d;
  logic       pend_q, pend_d;
  logic       cs_q, cs_d;
  logic       rd_q, rd_d;
  logic       err_q, err_d;
  logic       accept;
  logic       cap_hi, cap_lo;
  logic             tmr_ld;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             acq_ok;

  // reset: asserted asynchronously, released through two flops
  adc_rd_sync #(.STAGES(2), .RST_VAL(1'b0)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  adc_rd_sync #(.STAGES(2), .RST_VAL(1'b0)) i_busy_sync (
    .clk(clk), .rst_n(rst_n_s), .d(adc_busy), .q(busy_s)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_prev_q <= 1'b0;
    end else begin
      busy_prev_q <= busy_s;
    end
  end

  assign busy_fall = busy_prev_q && !busy_s;

  adc_rd_timer #(.CW(CNT_W)) i_step_tmr (
    .clk(clk), .rst_n(rst_n_s), .ld(tmr_ld), .ld_val(tmr_val), .zero(tmr_zero)
  );

  // acquisition gap: restarted on every end of conversion
  adc_rd_timer #(.CW(CNT_W)) i_acq_tmr (
    .clk(clk), .rst_n(rst_n_s), .ld(busy_fall), .ld_val(CNT_W'(ACQ_CYC)), .zero(acq_ok)
  );

  always_comb begin
    state_d = state_q;
    conv_d  = conv_q;
    mode_d  = mode_q;
    err_d   = 1'b0;
    accept  = 1'b0;
    cap_hi  = 1'b0;
    cap_lo  = 1'b0;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_q) begin
          accept = 1'b1;
          mode_d = pd_mode;
          if (!conv_q) begin
            conv_d  = 1'b1;
            state_d = ST_PWRUP;
            tmr_ld  = 1'b1;
            tmr_val = CNT_W'(PWRUP_CYC);
          end else begin
            state_d = ST_ARM;
          end
        end
      end
      ST_PWRUP: begin
        if (tmr_zero) state_d = ST_ARM;
      end
      ST_ARM: begin
        if (acq_ok) begin
          conv_d = 1'b0;
          tmr_ld = 1'b1;
          if (mode_q) begin
            state_d = ST_WAITB;
            tmr_val = CNT_W'(TIMEOUT_CYC);
          end else begin
            state_d = ST_CNVLO;
            tmr_val = CNT_W'(CNV_LOW_CYC);
          end
        end
      end
      ST_CNVLO: begin
        if (tmr_zero) begin
          conv_d  = 1'b1;
          state_d = ST_WAITB;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(TIMEOUT_CYC);
        end
      end
      ST_WAITB: begin
        if (busy_fall) begin
          state_d = ST_CS1;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(CS_SETUP_CYC);
        end else if (tmr_zero) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_CS1: begin
        if (tmr_zero) begin
          state_d = ST_RD1;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(RD_CYC);
        end
      end
      ST_RD1: begin
        if (tmr_zero) begin
          cap_hi  = 1'b1;
          state_d = ST_REC;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(RD_CYC);
        end
      end
      ST_REC: begin
        if (tmr_zero) begin
          state_d = ST_CS2;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(CS_SETUP_CYC);
        end
      end
      ST_CS2: begin
        if (tmr_zero) begin
          state_d = ST_RD2;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(RD_CYC);
        end
      end
      ST_RD2: begin
        if (tmr_zero) begin
          cap_lo  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_d = sample_req || (pend_q && !accept);
    cs_d   = (state_d == ST_CS1) || (state_d == ST_RD1) ||
             (state_d == ST_CS2) || (state_d == ST_RD2);
    rd_d   = (state_d == ST_RD1) || (state_d == ST_RD2);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      conv_q  <= 1'b0;
      mode_q  <= 1'b0;
      pend_q  <= 1'b0;
      cs_q    <= 1'b0;
      rd_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      conv_q  <= conv_d;
      mode_q  <= mode_d;
      pend_q  <= pend_d;
      cs_q    <= cs_d;
      rd_q    <= rd_d;
      err_q   <= err_d;
    end
  end

  adc_rd_pack #(.RES_W(RES_W), .BUS_W(BUS_W)) i_pack (
    .clk(clk), .rst_n(rst_n_s), .cap_hi(cap_hi), .cap_lo(cap_lo),
    .byte_in(adc_data), .res(sample_data), .res_vld(sample_valid)
  );

  assign adc_convst_n = conv_q;
  assign adc_cs_n     = !cs_q;
  assign adc_rd_n     = !rd_q;
  assign sample_err   = err_q;

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int unsigned RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_cs_n,
  input logic             adc_rd_n,
  input logic [RES_W-1:0] sample_data,
  input logic             sample_valid,
  input logic             sample_err
);

  // R5: read strobe only inside a chip-select window
  p_rd_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> !adc_cs_n);

  // R6: valid lasts one cycle
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R6: a result always follows the end of a read strobe
  p_valid_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> !$past(adc_rd_n));

  // R6: result moves only with valid
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample_data) |-> sample_valid);

  // R7: error lasts one cycle
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_err |=> !sample_err);

  // R7: error never coincides with a read
  p_err_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_err |-> (adc_cs_n && $past(adc_cs_n)));

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.RES_W(RES_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
  .sample_data(sample_data), .sample_valid(sample_valid), .sample_err(sample_err)
);

// File: tb/test_adc_rd_ctrl.sv
`timescale 1ns/1ps
module test_adc_rd_ctrl;

  localparam int CNV_LOW = 3;
  localparam int PWRUP   = 12;
  localparam int ACQ     = 30;
  localparam int SETUP   = 2;
  localparam int RDW     = 3;
  localparam int TMO     = 60;
  localparam int CONV    = 25;

  logic       clk;
  logic       rst_n;
  logic       sample_req;
  logic       pd_mode;
  logic       adc_busy;
  logic [7:0] adc_data;
  logic       adc_convst_n;
  logic       adc_cs_n;
  logic       adc_rd_n;
  logic [9:0] sample_data;
  logic       sample_valid;
  logic       sample_err;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  int ecount = 0;
  bit mute   = 0;
  bit done   = 0;

  logic [9:0] adc_q[$];
  logic [9:0] exp_q[$];

  adc_rd_ctrl #(
    .RES_W(10), .BUS_W(8), .CNV_LOW_CYC(CNV_LOW), .PWRUP_CYC(PWRUP),
    .ACQ_CYC(ACQ), .CS_SETUP_CYC(SETUP), .RD_CYC(RDW), .TIMEOUT_CYC(TMO)
  ) i_adc_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_req(sample_req), .pd_mode(pd_mode),
    .adc_busy(adc_busy), .adc_data(adc_data), .adc_convst_n(adc_convst_n),
    .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .sample_data(sample_data),
    .sample_valid(sample_valid), .sample_err(sample_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural converter and protocol monitor, all at the falling clock edge
  bit         prev_cv = 0, prev_rd = 1;
  bit         powered = 0, pu_flag = 0, last_norm = 0;
  int         cv_lo = 0, cv_hi = 0, rd_lo = 0, cs_lo = 0;
  int         conv_cnt = 0, since_bf = 1000, rd_idx = 0;
  logic [9:0] cur = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      adc_busy <= 1'b0;
      adc_data <= 8'hC3;
    end else begin
      // convert-start edges
      if (!prev_cv && adc_convst_n) begin
        if (last_norm) check(cv_lo == CNV_LOW, "R2 low pulse width", cv_lo, CNV_LOW);
        pu_flag = !last_norm;
        powered = 1;
      end
      if (prev_cv && !adc_convst_n) begin
        if (pu_flag) check(cv_hi >= PWRUP, "R3 power-up wait", cv_hi, PWRUP);
        check(powered, "R3 start while powered down", powered, 1);
        check(since_bf >= ACQ, "R4 acquisition gap", since_bf, ACQ);
        pu_flag   = 0;
        last_norm = !pd_mode;
        if (!mute && powered) begin
          cur      = (adc_q.size() > 0) ? adc_q.pop_front() : 10'h000;
          conv_cnt = CONV;
          rd_idx   = 0;
          adc_busy <= 1'b1;
        end
      end
      if (conv_cnt > 0) begin
        conv_cnt--;
        if (conv_cnt == 0) begin
          adc_busy <= 1'b0;
          since_bf = 0;
          if (!adc_convst_n) powered = 0;
        end
      end else begin
        since_bf++;
      end
      // read strobe edges
      if (prev_rd && !adc_rd_n) begin
        check(cs_lo == SETUP, "R5 chip-select lead", cs_lo, SETUP);
        check(!mute, "R7 read after timeout", mute, 0);
      end
      if (!prev_rd && adc_rd_n) begin
        check(rd_lo == RDW, "R5 read strobe width", rd_lo, RDW);
        rd_idx++;
      end
      if (!adc_rd_n && adc_cs_n) check(0, "R5 read outside chip-select", 1, 0);
      if (!adc_cs_n && !adc_rd_n)
        adc_data <= (rd_idx == 0) ? cur[9:2] : {cur[1:0], 6'b101101};
      else
        adc_data <= 8'hC3;
      // results
      if (sample_valid) begin
        vcount++;
        if (exp_q.size() == 0) check(0, "R8 unexpected result", vcount, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check(sample_data == e, "R6 result value", sample_data, e);
        end
        check(adc_convst_n == !pd_mode, "R2/R3 convert-start rest level",
              adc_convst_n, !pd_mode);
      end
      if (sample_err) begin
        ecount++;
        check(mute, "R7 unexpected error", 1, 0);
      end
      cv_lo = adc_convst_n ? 0 : cv_lo + 1;
      cv_hi = adc_convst_n ? cv_hi + 1 : 0;
      rd_lo = adc_rd_n ? 0 : rd_lo + 1;
      cs_lo = adc_cs_n ? 0 : cs_lo + 1;
      prev_cv = adc_convst_n;
      prev_rd = adc_rd_n;
    end
  end

  task automatic pulse_req();
    @(negedge clk);
    sample_req = 1'b1;
    @(negedge clk);
    sample_req = 1'b0;
  endtask

  task automatic wait_results(input int n, input string req);
    for (int i = 0; i < 4000 && vcount < n; i++) @(negedge clk);
    check(vcount == n, req, vcount, n);
  endtask

  task automatic one_sample(input logic [9:0] code, input string req);
    int target;
    adc_q.push_back(code);
    exp_q.push_back(code);
    target = vcount + 1;
    pulse_req();
    wait_results(target, req);
  endtask

  initial begin
    sample_req = 1'b0;
    pd_mode    = 1'b0;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    check(adc_convst_n == 1'b0, "R1 convert-start in reset", adc_convst_n, 0);
    check(adc_cs_n == 1'b1 && adc_rd_n == 1'b1, "R1 strobes in reset", {adc_cs_n, adc_rd_n}, 3);
    check(!sample_valid && !sample_err, "R1 flags in reset", {sample_valid, sample_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(adc_convst_n == 1'b0 && adc_cs_n && adc_rd_n, "R1 state after reset",
          adc_convst_n, 0);

    // fast mode: first sample powers up, later ones are plain pulses (R2, R3, R6)
    one_sample(10'h3FF, "R3 first sample after reset");
    one_sample(10'h000, "R2 fast sample zero");
    one_sample(10'h2A5, "R6 fast sample pattern");
    one_sample(10'h001, "R6 lsb only");

    // power-saving mode (R3)
    pd_mode = 1'b1;
    one_sample(10'h155, "R3 power-down sample a");
    one_sample(10'h202, "R3 power-down sample b");

    // request held during a sample (R8)
    begin
      int target;
      adc_q.push_back(10'h0F3); exp_q.push_back(10'h0F3);
      adc_q.push_back(10'h30C); exp_q.push_back(10'h30C);
      target = vcount + 2;
      pulse_req();
      repeat (20) @(negedge clk);
      pulse_req();
      wait_results(target, "R8 held request served");
    end

    // timeout in fast mode (R7)
    pd_mode = 1'b0;
    one_sample(10'h111, "R2 fast sample before timeout");
    begin
      int vbefore;
      vbefore = vcount;
      mute = 1'b1;
      pulse_req();
      for (int i = 0; i < 400 && ecount == 0; i++) @(negedge clk);
      check(ecount == 1, "R7 error pulse", ecount, 1);
      repeat (10) @(negedge clk);
      check(vcount == vbefore, "R7 no result after timeout", vcount, vbefore);
      mute = 1'b0;
    end
    one_sample(10'h3C7, "R7 recovery after timeout");

    check(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule